// File: doc/BRIEF.md
# Operand-Selecting Three-Input Arithmetic Unit

This is a purely combinational arithmetic block with three 8-bit operand inputs. Each operand has its own enable input. Only enabled operands take part in the operation. Three opcode flags select one of three operations:

- a two-operand sum;
- a two-operand difference;
- a chained operation that adds the first two operands and subtracts the third, in one pass.

The block also checks the operand count. Each operation needs a fixed number of enabled operands. If the count is wrong, or if the opcode flags form a pattern that names no operation, the block raises an error flag and drives the result to zero. All arithmetic wraps modulo 256, and there is no carry or borrow output. The block is intended for a datapath in which a controller picks the live operands and the operation in the same cycle and reads the result back combinationally.

Top module: `arith3_unit`

## Requirements
- R1: All arithmetic wraps modulo 256, with no carry or borrow output. For example, 200 + 100 gives 44, and 12 - 22 gives 246.
- R2: When only `op_add` is high and exactly two enables are set, `result` is the sum of the two enabled operands, and `err` is low.
- R3: When only `op_sub` is high and exactly two enables are set, `result` is the lower-lettered enabled operand minus the other enabled operand, and `err` is low. The letter order is a, then b, then c.
- R4: When `op_add`, `op_sub` and `op_chain` are all high and all three enables are set, `result` is a + b - c and `err` is low.
- R5: When only `op_add` or only `op_sub` is high and the number of enabled operands is not two, `err` is high and `result` is 0.
- R6: When all three opcode flags are high and fewer than three operands are enabled, `err` is high and `result` is 0.
- R7: The flag pattern {op_add, op_sub, op_chain} names an operation only when it is 100, 010 or 111. Every other nonzero pattern sets `err` high and `result` to 0.
- R8: When all three opcode flags are low, `result` is 0 and `err` is low, whatever the enables are.
- R9: The value of an operand whose enable is low has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | Operand a (lowest letter) |
| opnd_b | input | 8 | Operand b |
| opnd_c | input | 8 | Operand c (highest letter) |
| en_a | input | 1 | Operand a takes part |
| en_b | input | 1 | Operand b takes part |
| en_c | input | 1 | Operand c takes part |
| op_add | input | 1 | Opcode flag: add |
| op_sub | input | 1 | Opcode flag: subtract |
| op_chain | input | 1 | Opcode flag: chained add then subtract (with the other two flags) |
| result | output | 8 | Arithmetic result, 0 on error or when idle |
| err | output | 1 | Operand count or opcode pattern is not legal |

## Verification
Sums are tried on all three operand pairs. These cases show that operand selection follows the enables and not fixed ports. Differences are applied to each pair and in both magnitude orders. This separates the lower-letter-first rule from a swapped minuend, and confirms the borrow wrap. The chained operation is checked with and without wraparound, and with a missing operand. Every illegal flag pattern, every count mismatch and the all-low idle case are applied. Sweeps of a disabled operand confirm that it leaves the result untouched.

// File: rtl/arith3_pkg.sv
package arith3_pkg;

  typedef enum logic [1:0] {
    OPK_IDLE  = 2'd0,
    OPK_ADD   = 2'd1,
    OPK_SUB   = 2'd2,
    OPK_CHAIN = 2'd3
  } opkind_e;

  // flag bit order: [2] add, [1] sub, [0] chain
  localparam logic [2:0] FLAGS_IDLE  = 3'b000;
  localparam logic [2:0] FLAGS_ADD   = 3'b100;
  localparam logic [2:0] FLAGS_SUB   = 3'b010;
  localparam logic [2:0] FLAGS_CHAIN = 3'b111;

  function automatic logic [7:0] wrap_add8(input logic [7:0] x, input logic [7:0] y);
    return x + y;
  endfunction

  function automatic logic [7:0] wrap_sub8(input logic [7:0] x, input logic [7:0] y);
    return x - y;
  endfunction

endpackage

// File: rtl/opsel_decode.sv
module opsel_decode
  import arith3_pkg::*;
#(
  parameter int NUM_OPS = 3,
  localparam int CNT_W = $clog2(NUM_OPS + 1)
) (
  input  logic [2:0]       flags,
  output opkind_e          kind,
  output logic             legal,
  output logic [CNT_W-1:0] need_cnt
);

  always_comb begin
    kind     = OPK_IDLE;
    legal    = 1'b1;
    need_cnt = '0;
    unique case (flags)
      FLAGS_IDLE: ;
      FLAGS_ADD: begin
        kind     = OPK_ADD;
        need_cnt = CNT_W'(2);
      end
      FLAGS_SUB: begin
        kind     = OPK_SUB;
        need_cnt = CNT_W'(2);
      end
      FLAGS_CHAIN: begin
        kind     = OPK_CHAIN;
        need_cnt = CNT_W'(NUM_OPS);
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/operand_pick.sv
module operand_pick #(
  parameter int WIDTH   = 8,
  parameter int NUM_OPS = 3,
  localparam int CNT_W = $clog2(NUM_OPS + 1)
) (
  input  logic [WIDTH-1:0] opnd [NUM_OPS],
  input  logic [NUM_OPS-1:0] en,
  output logic [WIDTH-1:0] first,
  output logic [WIDTH-1:0] second,
  output logic [CNT_W-1:0] count,
  output logic [WIDTH-1:0] chain_val
);

  // lowest-index enabled operand is first, next one is second
  always_comb begin
    first  = '0;
    second = '0;
    count  = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (en[i]) begin
        if (count == CNT_W'(0))      first  = opnd[i];
        else if (count == CNT_W'(1)) second = opnd[i];
        count = count + CNT_W'(1);
      end
    end
  end

  // sum of all but the last operand, minus the last one
  always_comb begin
    chain_val = '0;
    for (int i = 0; i < NUM_OPS - 1; i++) begin
      chain_val = chain_val + opnd[i];
    end
    chain_val = chain_val - opnd[NUM_OPS-1];
  end

endmodule

// File: rtl/arith_core.sv
module arith_core
  import arith3_pkg::*;
(
  input  opkind_e    kind,
  input  logic [7:0] first,
  input  logic [7:0] second,
  input  logic [7:0] chain_val,
  output logic [7:0] raw
);

  always_comb begin
    unique case (kind)
      OPK_ADD:   raw = wrap_add8(first, second);
      OPK_SUB:   raw = wrap_sub8(first, second);
      OPK_CHAIN: raw = chain_val;
      default:   raw = '0;
    endcase
  end

endmodule

// File: rtl/arith3_unit.sv
module arith3_unit
  import arith3_pkg::*;
(
  input  logic [7:0] opnd_a,
  input  logic [7:0] opnd_b,
  input  logic [7:0] opnd_c,
  input  logic       en_a,
  input  logic       en_b,
  input  logic       en_c,
  input  logic       op_add,
  input  logic       op_sub,
  input  logic       op_chain,
  output logic [7:0] result,
  output logic       err
);

  localparam int WIDTH   = 8;
  localparam int NUM_OPS = 3;
  localparam int CNT_W   = $clog2(NUM_OPS + 1);

  logic [WIDTH-1:0]   opnd_vec [NUM_OPS];
  logic [NUM_OPS-1:0] en_vec;
  logic [2:0]         flags;

  assign opnd_vec[0] = opnd_a;
  assign opnd_vec[1] = opnd_b;
  assign opnd_vec[2] = opnd_c;
  assign en_vec      = {en_c, en_b, en_a};
  assign flags       = {op_add, op_sub, op_chain};

  opkind_e          kind;
  logic             op_legal;
  logic [CNT_W-1:0] need_cnt;
  logic [CNT_W-1:0] have_cnt;
  logic [WIDTH-1:0] first, second, chain_val, raw;
  logic             cnt_ok;
  logic             is_idle;

  opsel_decode #(.NUM_OPS(NUM_OPS)) u_dec (
    .flags    (flags),
    .kind     (kind),
    .legal    (op_legal),
    .need_cnt (need_cnt)
  );

  operand_pick #(.WIDTH(WIDTH), .NUM_OPS(NUM_OPS)) u_pick (
    .opnd      (opnd_vec),
    .en        (en_vec),
    .first     (first),
    .second    (second),
    .count     (have_cnt),
    .chain_val (chain_val)
  );

  arith_core u_core (
    .kind      (kind),
    .first     (first),
    .second    (second),
    .chain_val (chain_val),
    .raw       (raw)
  );

  assign cnt_ok  = (have_cnt == need_cnt);
  assign is_idle = op_legal && (kind == OPK_IDLE);
  assign err     = !op_legal || (!is_idle && !cnt_ok);
  assign result  = (err || is_idle) ? '0 : raw;

endmodule

// File: rtl/arith3_unit_chk.sv
module arith3_unit_chk (
  input logic [7:0] opnd_a,
  input logic [7:0] opnd_b,
  input logic [7:0] opnd_c,
  input logic       en_a,
  input logic       en_b,
  input logic       en_c,
  input logic       op_add,
  input logic       op_sub,
  input logic       op_chain,
  input logic [7:0] result,
  input logic       err,
  input logic       op_legal,
  input logic       cnt_ok
);

  logic [1:0] n_en;
  logic [2:0] fl;
  logic [7:0] masked_sum;
  logic [7:0] low_minus_high;

  always_comb begin
    n_en = 2'(en_a) + 2'(en_b) + 2'(en_c);
    fl   = {op_add, op_sub, op_chain};
    masked_sum = (en_a ? opnd_a : 8'd0) + (en_b ? opnd_b : 8'd0) + (en_c ? opnd_c : 8'd0);
    low_minus_high = en_a ? (opnd_a - (en_b ? opnd_b : opnd_c)) : (opnd_b - opnd_c);
  end

  always_comb begin
    p_err_zero_r5: assert (!err || result == 8'd0)
      else $error("error without zero result");
    p_idle_quiet_r8: assert (fl != 3'b000 || (!err && result == 8'd0))
      else $error("idle flags not quiet");
    p_bad_flags_r7: assert (fl == 3'b000 || fl == 3'b100 || fl == 3'b010 || fl == 3'b111 || (err && !op_legal))
      else $error("illegal flags not flagged");
    p_add_sum_r2: assert (!(fl == 3'b100 && n_en == 2'd2) || (!err && cnt_ok && result == masked_sum))
      else $error("add result wrong");
    p_sub_order_r3: assert (!(fl == 3'b010 && n_en == 2'd2) || (!err && result == low_minus_high))
      else $error("sub result wrong");
    p_chain_val_r4: assert (!(fl == 3'b111 && n_en == 2'd3) || (!err && result == 8'(opnd_a + opnd_b - opnd_c)))
      else $error("chain result wrong");
    p_two_cnt_r5: assert (!((fl == 3'b100 || fl == 3'b010) && n_en != 2'd2) || err)
      else $error("count mismatch not flagged");
    p_chain_cnt_r6: assert (!(fl == 3'b111 && n_en != 2'd3) || err)
      else $error("chain count mismatch not flagged");
  end

endmodule

bind arith3_unit arith3_unit_chk u_chk (.*);

// File: tb/arith3_unit_bench.sv
`timescale 1ns/1ps
module arith3_unit_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] opnd_a, opnd_b, opnd_c, result;
  logic en_a, en_b, en_c, op_add, op_sub, op_chain, err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  arith3_unit u_arith3_unit (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .en_a(en_a), .en_b(en_b), .en_c(en_c),
    .op_add(op_add), .op_sub(op_sub), .op_chain(op_chain),
    .result(result), .err(err)
  );

  // row: a, b, c, enables {a,b,c}, flags {add,sub,chain}, expected result, expected err
  localparam int NV = 18;
  localparam logic [38:0] VEC [NV] = '{
    {8'd11,  8'd22,  8'd99, 3'b110, 3'b100, 8'd33,  1'b0}, // R2 a+b
    {8'd11,  8'd22,  8'd99, 3'b011, 3'b100, 8'd121, 1'b0}, // R2 b+c
    {8'd11,  8'd22,  8'd99, 3'b101, 3'b100, 8'd110, 1'b0}, // R2 a+c
    {8'd200, 8'd100, 8'd0,  3'b110, 3'b100, 8'd44,  1'b0}, // R1 add wrap
    {8'd22,  8'd12,  8'd99, 3'b110, 3'b010, 8'd10,  1'b0}, // R3 a-b
    {8'd12,  8'd22,  8'd0,  3'b110, 3'b010, 8'd246, 1'b0}, // R1 R3 borrow wrap
    {8'd5,   8'd40,  8'd15, 3'b011, 3'b010, 8'd25,  1'b0}, // R3 b-c
    {8'd9,   8'd5,   8'd7,  3'b101, 3'b010, 8'd2,   1'b0}, // R3 a-c
    {8'd22,  8'd12,  8'd3,  3'b111, 3'b111, 8'd31,  1'b0}, // R4
    {8'd250, 8'd10,  8'd1,  3'b111, 3'b111, 8'd3,   1'b0}, // R4 wrap
    {8'd22,  8'd12,  8'd3,  3'b111, 3'b010, 8'd0,   1'b1}, // R5 sub with three
    {8'd11,  8'd22,  8'd99, 3'b001, 3'b100, 8'd0,   1'b1}, // R5 add with one
    {8'd0,   8'd0,   8'd0,  3'b000, 3'b100, 8'd0,   1'b1}, // R5 add with none
    {8'd22,  8'd12,  8'd3,  3'b110, 3'b111, 8'd0,   1'b1}, // R6
    {8'd1,   8'd2,   8'd3,  3'b111, 3'b110, 8'd0,   1'b1}, // R7
    {8'd1,   8'd2,   8'd3,  3'b110, 3'b011, 8'd0,   1'b1}, // R7
    {8'd1,   8'd2,   8'd3,  3'b110, 3'b001, 8'd0,   1'b1}, // R7
    {8'd1,   8'd2,   8'd3,  3'b111, 3'b000, 8'd0,   1'b0}  // R8
  };

  task automatic apply(input logic [7:0] a, b, c, input logic [2:0] en, input logic [2:0] fl);
    @(posedge clk);
    opnd_a = a; opnd_b = b; opnd_c = c;
    {en_a, en_b, en_c} = en;
    {op_add, op_sub, op_chain} = fl;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp_r, input logic exp_e);
    checks++;
    if (result !== exp_r || err !== exp_e) begin
      fails++;
      $display("FAIL %s: result=%0d err=%0b expected result=%0d err=%0b", req, result, err, exp_r, exp_e);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8 initial all-low state
    apply(8'd0, 8'd0, 8'd0, 3'b000, 3'b000);
    check("R8 all low", 8'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][38:31], VEC[i][30:23], VEC[i][22:15], VEC[i][14:12], VEC[i][11:9]);
      check($sformatf("vector %0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // R9 disabled c swept under add of a and b
    for (int v = 0; v < 256; v += 37) begin
      apply(8'd70, 8'd9, 8'(v), 3'b110, 3'b100);
      check("R9 disabled c add", 8'd79, 1'b0);
    end
    // R9 disabled a swept under subtract of b and c
    for (int v = 0; v < 256; v += 51) begin
      apply(8'(v), 8'd50, 8'd8, 3'b011, 3'b010);
      check("R9 disabled a sub", 8'd42, 1'b0);
    end
    // R8 idle with all enables on and busy operands
    apply(8'd255, 8'd255, 8'd255, 3'b111, 3'b000);
    check("R8 idle enables", 8'd0, 1'b0);
    // R1 chain wrap negative: 1+2-10 = 249
    apply(8'd1, 8'd2, 8'd10, 3'b111, 3'b111);
    check("R1 chain borrow", 8'd249, 1'b0);
    // R6 chain with none enabled
    apply(8'd1, 8'd2, 8'd3, 3'b000, 3'b111);
    check("R6 chain none", 8'd0, 1'b1);
    // R7 remaining illegal patterns
    apply(8'd1, 8'd2, 8'd3, 3'b110, 3'b101);
    check("R7 flags 101", 8'd0, 1'b1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule